// File: doc/BRIEF.md
# Tracking Shaft-Angle Counter with Turns Outputs

This block keeps the digital shaft angle of a tracking resolver-to-digital converter loop. The analog part of the loop is outside the block: it issues one-cycle step requests with a direction bit, and a step-enable line. The step-enable line is driven low when the loop error is smaller than one LSB. Each accepted step moves the 16-bit natural-binary angle by one LSB of the resolution chosen at run time. The most significant bit carries 180 degrees. Each accepted step also starts a handshake pulse (`busy`). A step that carries the angle through zero degrees then gives an active-low turns pulse (`ripple_n`). The `dir_cw` level reports the direction of the last step.

The angle is read through a holding latch. Pulling `inhibit_n` low freezes the latch so a reader can sample a stable word while the counter keeps tracking. When `inhibit_n` rises, the latch reloads and `busy` pulses once. The read port drives data only while `out_en_n` is low. A low `load_n` presets the counter from `load_data`. It works as a transparent latch whose last value is kept on the trailing edge.

Pulses are produced by a sequencer with three states. SQ_IDLE goes to SQ_BUSY on an accepted step or on an inhibit rise. SQ_BUSY lasts BUSY_W clocks. It then goes to SQ_RIPPLE if the step crossed zero, and back to SQ_IDLE otherwise. SQ_RIPPLE lasts RIP_W clocks and then returns to SQ_IDLE.

Top module: `shaft_angle_tracker`

## Requirements
- R1: After reset the angle is 0000h, `busy` is low, `ripple_n` is high and `dir_cw` is high.
- R2: `res_sel` picks the resolution: 00 is 10 bits, 01 is 12 bits, 10 is 14 bits, 11 is 16 bits. A step changes the angle by 2^(16-N), and the bits below the resolution LSB always read zero.
- R3: A step is accepted on a clock where `step_req`, `step_en` and `load_n` are high and the sequencer is in SQ_IDLE. `step_dir`=1 adds and `step_dir`=0 subtracts, modulo 2^16. With `step_en` low a request does nothing.
- R4: `busy` is high for exactly BUSY_W clocks, starting on the clock after an accepted step.
- R5: `dir_cw` takes the `step_dir` value of the last accepted step.
- R6: `ripple_n` goes low for RIP_W clocks directly after the `busy` pulse, but only when the step went up from the top code to 0000h or down from 0000h. It is never low while `busy` is high.
- R7: A step request that arrives while a `busy` or `ripple_n` pulse is in progress is dropped.
- R8: While `inhibit_n` is low, `angle_out` holds its value and the counter keeps tracking. When `inhibit_n` rises, the latch shows the current count and `busy` pulses for BUSY_W clocks with no ripple.
- R9: While `out_en_n` is high, `angle_valid` is low and `angle_out` reads zero. While `out_en_n` is low, `angle_valid` is high.
- R10: While `load_n` is low, the counter follows `load_data` (masked to the resolution) and any step request is dropped. The last value loaded is kept after `load_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_sel | input | 2 | Resolution select |
| step_req | input | 1 | One-cycle step request from the loop |
| step_dir | input | 1 | Step direction, 1 = up |
| step_en | input | 1 | Step gate, low when the loop error is below one LSB |
| inhibit_n | input | 1 | Low freezes the output latch |
| out_en_n | input | 1 | Low drives the angle port |
| load_n | input | 1 | Low presets the counter |
| load_data | input | 16 | Preset value |
| angle_out | output | 16 | Latched angle |
| angle_valid | output | 1 | Angle port is driven |
| busy | output | 1 | Step and reload handshake pulse |
| dir_cw | output | 1 | Direction of the last step |
| ripple_n | output | 1 | Active-low zero-crossing pulse |

## Verification
The bench goes after the zero crossing in both directions and at coarse resolution. A design that compares the wrong value would either miss the down-going ripple or fire it on an ordinary step to zero. It switches the resolution while the counter holds stale low bits; a counter that did not mask first would step to an off-grid code. It also sends back-to-back requests during `busy`, a step on the same clock as a preset, and a step while the latch is inhibited. These catch, in turn, double counting, a preset lost to a step, and a latch that leaks counts or misses its reload pulse.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int ANG_W = 16;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_BUSY   = 2'd1,
        SQ_RIPPLE = 2'd2
    } seq_state_t;

    // Weight of one LSB at the selected resolution (00:10b .. 11:16b)
    function automatic logic [ANG_W-1:0] lsb_weight(input logic [1:0] sel);
        logic [2:0] sh;
        sh = 3'd6 - {sel, 1'b0};
        return ANG_W'(1) << sh;
    endfunction

    function automatic logic [ANG_W-1:0] res_mask(input logic [1:0] sel);
        return ~(lsb_weight(sel) - ANG_W'(1));
    endfunction
endpackage

// File: rtl/sat_angle_counter.sv
module sat_angle_counter
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       res_sel,
    input  logic             do_step,
    input  logic             step_up,
    input  logic             load_act,
    input  logic [ANG_W-1:0] load_data,
    output logic [ANG_W-1:0] cnt_next,
    output logic             wrap,
    output logic             dir_q
);
    logic [ANG_W-1:0] cnt_q;
    logic [ANG_W-1:0] weight;
    logic [ANG_W-1:0] mask;
    logic [ANG_W-1:0] base;

    always_comb begin
        weight   = lsb_weight(res_sel);
        mask     = res_mask(res_sel);
        base     = cnt_q & mask;
        cnt_next = cnt_q;
        wrap     = 1'b0;
        if (load_act) begin
            cnt_next = load_data & mask;
        end else if (do_step) begin
            if (step_up) begin
                cnt_next = base + weight;
                wrap     = (cnt_next == '0);
            end else begin
                cnt_next = base - weight;
                wrap     = (base == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
        end else begin
            cnt_q <= cnt_next;
            if (do_step) dir_q <= step_up;
        end
    end
endmodule

// File: rtl/sat_pulse_seq.sv
module sat_pulse_seq
    import sat_pkg::*;
#(
    parameter int BUSY_W = 3,
    parameter int RIP_W  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_step,
    input  logic start_inh,
    input  logic wrap_in,
    output logic idle,
    output logic busy,
    output logic ripple_n
);
    localparam int MAXW = (BUSY_W > RIP_W) ? BUSY_W : RIP_W;
    localparam int CW   = $clog2(MAXW + 1);

    seq_state_t      st_q, st_n;
    logic [CW-1:0]   cd_q, cd_n;
    logic            wr_q, wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
            cd_q <= '0;
            wr_q <= 1'b0;
        end else begin
            st_q <= st_n;
            cd_q <= cd_n;
            wr_q <= wr_n;
        end
    end

    always_comb begin
        st_n = st_q;
        cd_n = cd_q;
        wr_n = wr_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (start_step) begin
                    st_n = SQ_BUSY;
                    cd_n = CW'(BUSY_W - 1);
                    wr_n = wrap_in;
                end else if (start_inh) begin
                    st_n = SQ_BUSY;
                    cd_n = CW'(BUSY_W - 1);
                    wr_n = 1'b0;
                end
            end
            SQ_BUSY: begin
                if (cd_q == '0) begin
                    if (wr_q) begin
                        st_n = SQ_RIPPLE;
                        cd_n = CW'(RIP_W - 1);
                    end else begin
                        st_n = SQ_IDLE;
                    end
                end else begin
                    cd_n = cd_q - CW'(1);
                end
            end
            SQ_RIPPLE: begin
                if (cd_q == '0) st_n = SQ_IDLE;
                else            cd_n = cd_q - CW'(1);
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    always_comb begin
        idle     = (st_q == SQ_IDLE);
        busy     = (st_q == SQ_BUSY);
        ripple_n = (st_q != SQ_RIPPLE);
    end
endmodule

// File: rtl/sat_out_latch.sv
module sat_out_latch
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       res_sel,
    input  logic             inhibit_n,
    input  logic             out_en_n,
    input  logic [ANG_W-1:0] cnt_next,
    output logic             inh_rise,
    output logic [ANG_W-1:0] angle_out,
    output logic             angle_valid
);
    logic [ANG_W-1:0] hold_q;
    logic             inh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            inh_q  <= 1'b1;
        end else begin
            inh_q <= inhibit_n;
            if (inhibit_n) hold_q <= cnt_next & res_mask(res_sel);
        end
    end

    always_comb begin
        inh_rise    = inhibit_n & ~inh_q;
        angle_valid = ~out_en_n;
        angle_out   = out_en_n ? '0 : hold_q;
    end
endmodule

// File: rtl/shaft_angle_tracker.sv
module shaft_angle_tracker
    import sat_pkg::*;
#(
    parameter int BUSY_W = 3,
    parameter int RIP_W  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  res_sel,
    input  logic        step_req,
    input  logic        step_dir,
    input  logic        step_en,
    input  logic        inhibit_n,
    input  logic        out_en_n,
    input  logic        load_n,
    input  logic [15:0] load_data,
    output logic [15:0] angle_out,
    output logic        angle_valid,
    output logic        busy,
    output logic        dir_cw,
    output logic        ripple_n
);
    logic             seq_idle;
    logic             do_step;
    logic             wrap;
    logic             inh_rise;
    logic [ANG_W-1:0] cnt_next;

    assign do_step = step_req & step_en & load_n & seq_idle;

    sat_angle_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_sel   (res_sel),
        .do_step   (do_step),
        .step_up   (step_dir),
        .load_act  (~load_n),
        .load_data (load_data),
        .cnt_next  (cnt_next),
        .wrap      (wrap),
        .dir_q     (dir_cw)
    );

    sat_pulse_seq #(.BUSY_W(BUSY_W), .RIP_W(RIP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_step (do_step),
        .start_inh  (inh_rise),
        .wrap_in    (wrap),
        .idle       (seq_idle),
        .busy       (busy),
        .ripple_n   (ripple_n)
    );

    sat_out_latch u_lat (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_sel     (res_sel),
        .inhibit_n   (inhibit_n),
        .out_en_n    (out_en_n),
        .cnt_next    (cnt_next),
        .inh_rise    (inh_rise),
        .angle_out   (angle_out),
        .angle_valid (angle_valid)
    );
endmodule

// File: rtl/shaft_angle_tracker_chk.sv
module shaft_angle_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  res_sel,
    input logic        step_req,
    input logic        step_dir,
    input logic        step_en,
    input logic        inhibit_n,
    input logic        out_en_n,
    input logic        load_n,
    input logic [15:0] load_data,
    input logic [15:0] angle_out,
    input logic        angle_valid,
    input logic        busy,
    input logic        dir_cw,
    input logic        ripple_n
);
    p_lsb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inhibit_n) && res_sel == 2'b00 && $past(res_sel) == 2'b00) |-> angle_out[5:0] == 6'd0);

    p_busy_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(step_req && step_en && load_n) || ($past(inhibit_n) && !$past(inhibit_n, 2))));

    p_dir_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step_req && step_en && load_n && !busy && ripple_n) |-> dir_cw == $past(step_dir));

    p_ripple_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ripple_n) |-> $past(busy));

    p_busy_ripple_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && !ripple_n));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!inhibit_n) && !out_en_n && $past(!out_en_n)) |-> $stable(angle_out));

    p_port_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!angle_valid && angle_out == 16'd0));

    p_preset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!load_n) && $past(inhibit_n) && !out_en_n && $past(res_sel) == 2'b11) |-> angle_out == $past(load_data));
endmodule

bind shaft_angle_tracker shaft_angle_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .step_req(step_req),
    .step_dir(step_dir), .step_en(step_en), .inhibit_n(inhibit_n),
    .out_en_n(out_en_n), .load_n(load_n), .load_data(load_data),
    .angle_out(angle_out), .angle_valid(angle_valid), .busy(busy),
    .dir_cw(dir_cw), .ripple_n(ripple_n)
);

// File: tb/sim_shaft_angle_tracker.sv
`timescale 1ns/1ps
module sim_shaft_angle_tracker;
    localparam int BW = 3;
    localparam int RW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  res_sel = 2'b11;
    logic        step_req = 1'b0, step_dir = 1'b1, step_en = 1'b1;
    logic        inhibit_n = 1'b1, out_en_n = 1'b0, load_n = 1'b1;
    logic [15:0] load_data = 16'h0000;
    logic [15:0] angle_out;
    logic        angle_valid, busy, dir_cw, ripple_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shaft_angle_tracker #(.BUSY_W(BW), .RIP_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .step_req(step_req),
        .step_dir(step_dir), .step_en(step_en), .inhibit_n(inhibit_n),
        .out_en_n(out_en_n), .load_n(load_n), .load_data(load_data),
        .angle_out(angle_out), .angle_valid(angle_valid), .busy(busy),
        .dir_cw(dir_cw), .ripple_n(ripple_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_cnt, m_hold;
    logic        m_dir, m_inhp, m_wrap;
    int          m_phase, m_left;

    always @(posedge clk) begin
        logic [15:0] w, mk, b, nc;
        logic acc, rise, wr;
        if (!rst_n) begin
            m_cnt = 0; m_hold = 0; m_dir = 1; m_inhp = 1; m_wrap = 0;
            m_phase = 0; m_left = 0;
        end else begin
            w  = 16'd1 << (6 - 2 * int'(res_sel));
            mk = ~(w - 16'd1);
            rise = inhibit_n && !m_inhp;
            acc  = step_req && step_en && load_n && (m_phase == 0);
            nc = m_cnt; wr = 0;
            if (!load_n) nc = load_data & mk;
            else if (acc) begin
                b = m_cnt & mk;
                if (step_dir) begin nc = b + w; wr = (nc == 0); end
                else begin nc = b - w; wr = (b == 0); end
                m_dir = step_dir;
            end
            if (m_phase == 0) begin
                if (acc) begin m_phase = 1; m_left = BW; m_wrap = wr; end
                else if (rise) begin m_phase = 1; m_left = BW; m_wrap = 0; end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    if (m_phase == 1 && m_wrap) begin m_phase = 2; m_left = RW; end
                    else m_phase = 0;
                end
            end
            if (inhibit_n) m_hold = nc & mk;
            m_cnt = nc; m_inhp = inhibit_n;
        end
        #5;
        if (!done) begin
            check("R2/R3/R8/R9 model angle", angle_out, out_en_n ? 0 : m_hold);
            check("R9 model valid", angle_valid, !out_en_n);
            check("R4 model busy", busy, m_phase == 1);
            check("R6 model ripple_n", ripple_n, m_phase != 2);
            check("R5 model dir", dir_cw, m_dir);
        end
    end

    // ---------------- directed stimulus ----------------
    int nb, nr;

    task automatic watch(input int n);
        nb = 0; nr = 0;
        for (int i = 0; i < n; i++) begin
            if (busy) nb++;
            if (!ripple_n) nr++;
            @(negedge clk);
        end
    endtask

    task automatic step_once(input logic up);
        @(negedge clk); step_req = 1'b1; step_dir = up;
        @(negedge clk); step_req = 1'b0;
        watch(10);
    endtask

    task automatic set_res(input logic [1:0] r);
        @(negedge clk); res_sel = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset angle", angle_out, 16'h0000);
        check("R1 reset busy", busy, 0);
        check("R1 reset ripple_n", ripple_n, 1);
        check("R1 reset dir", dir_cw, 1);
        rst_n = 1'b1;
        @(negedge clk);

        step_once(1'b1);
        check("R3 up 16b", angle_out, 16'h0001);
        check("R4 busy width", nb, BW);
        check("R6 no ripple", nr, 0);
        step_once(1'b0);
        check("R3 down to zero", angle_out, 16'h0000);
        check("R6 step to zero no ripple", nr, 0);
        check("R5 dir down", dir_cw, 0);
        step_once(1'b0);
        check("R3 down wrap", angle_out, 16'hFFFF);
        check("R6 ripple down", nr, RW);

        set_res(2'b00);
        check("R2 masked 10b", angle_out, 16'hFFC0);
        step_once(1'b1);
        check("R2 up wrap 10b", angle_out, 16'h0000);
        check("R6 ripple up", nr, RW);
        check("R5 dir up", dir_cw, 1);
        step_once(1'b1);
        check("R2 10b weight", angle_out, 16'h0040);
        set_res(2'b01);
        step_once(1'b1);
        check("R2 12b weight", angle_out, 16'h0050);
        set_res(2'b10);
        step_once(1'b1);
        check("R2 14b weight", angle_out, 16'h0054);

        step_en = 1'b0;
        step_once(1'b1);
        check("R3 gated step", angle_out, 16'h0054);
        check("R3 gated no busy", nb, 0);
        step_en = 1'b1;

        @(negedge clk); step_req = 1'b1; step_dir = 1'b1;
        @(negedge clk);
        @(negedge clk); step_req = 1'b0;
        watch(10);
        check("R7 request during busy dropped", angle_out, 16'h0058);

        @(negedge clk); inhibit_n = 1'b0;
        step_once(1'b1);
        step_once(1'b1);
        check("R8 frozen", angle_out, 16'h0058);
        @(negedge clk); inhibit_n = 1'b1;
        @(negedge clk);
        check("R8 reload", angle_out, 16'h0060);
        watch(10);
        check("R8 reload busy", nb, BW);
        check("R8 reload no ripple", nr, 0);

        @(negedge clk); out_en_n = 1'b1;
        #1;
        check("R9 port off angle", angle_out, 0);
        check("R9 port off valid", angle_valid, 0);
        @(negedge clk); out_en_n = 1'b0;
        #1;
        check("R9 port on", angle_out, 16'h0060);

        @(negedge clk); load_n = 1'b0; load_data = 16'h1234; step_req = 1'b1; step_dir = 1'b0;
        @(negedge clk); step_req = 1'b0;
        check("R10 transparent", angle_out, 16'h1234);
        @(negedge clk); load_n = 1'b1; load_data = 16'hAAAA;
        watch(6);
        check("R10 preset kept", angle_out, 16'h1234);
        check("R10 step dropped busy", nb, 0);
        check("R10 dir unchanged", dir_cw, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule